// File: doc/BRIEF.md
# Programmable CPU Clock-Enable Rate Controller

This block lets a soft processor core, clocked from a fixed and faster system clock, run at a chosen whole number of MHz. It produces a one-system-cycle enable pulse, `cpu_ce`, that the core uses to qualify its registers. A phase accumulator spaces the pulses: each system cycle adds the active rate in MHz, and whenever the sum reaches the system clock frequency in MHz, that frequency is subtracted and a pulse is issued. Over any window of `SYS_MHZ` system cycles, exactly N pulses come out at rate N.

A write port takes a requested rate. A request of zero selects the 4 MHz default. A request above `MAX_MHZ` becomes `MAX_MHZ`. Any other value is used as given, so the 3 MHz and 4 MHz settings of the historical machines are ordinary settings. The limited value is held in a pending register. It becomes the active rate only at a system edge where the enable output is high, and the accumulator is never cleared when the rate changes. This means a change can neither add a pulse nor drop one. The active rate can be read back on `rate_q`.

The update path is a two-state machine:
- `ST_IDLE`: no request is pending.
- `ST_WAIT`: a limited request is held until the next pulse.

Its transitions are:
- **post** (`ST_IDLE`→`ST_WAIT`): a write arrives while the enable is low.
- **direct-apply** (`ST_IDLE`→`ST_IDLE`): a write arrives while the enable is high, so it is applied at once.
- **repost** (`ST_WAIT`→`ST_WAIT`): a write arrives while the enable is low and replaces the pending value.
- **commit** (`ST_WAIT`→`ST_IDLE`): the enable is high, so the newest value (the write on this edge, if there is one, or else the pending value) becomes active.

There are two resets:
- The power-on reset clears everything and returns the rate to 4 MHz.
- The soft break reset clears only the accumulator and the enable. The active rate and any pending request are kept.

Top module: `cerate_ctrl`

## Requirements
- R1: While `por_rst` is high and on the cycle after it, `rate_q` reads 4 and `cpu_ce` is low.
- R2: A written request of 0 becomes an active rate of 4.
- R3: A written request greater than `MAX_MHZ` becomes an active rate of `MAX_MHZ`.
- R4: A written request from 1 to `MAX_MHZ` becomes the active rate unchanged, including 3 and 4.
- R5: At a steady active rate N, every window of `SYS_MHZ` consecutive system cycles holds exactly N cycles with `cpu_ce` high.
- R6: `rate_q` changes only on the system edge right after a cycle in which `cpu_ce` was high. Writes made while `cpu_ce` is low leave `rate_q` unchanged until then.
- R7: When several writes arrive before the next pulse, the last one is the one that becomes active.
- R8: While `brk_rst` is high, `cpu_ce` is low from the next cycle on. `rate_q` keeps its value across the break. Pulsing resumes at that rate after release.
- R9: When `MAX_MHZ` equals `SYS_MHZ` and the active rate is the maximum, `cpu_ce` is high on every cycle.
- R10: The accumulator always stays below `SYS_MHZ`, so no more than one pulse is ever owed at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high; restores the default rate |
| brk_rst | input | 1 | Soft break reset, synchronous, active high; keeps the rate setting |
| wr_en | input | 1 | Write strobe for a rate request |
| wr_rate | input | RATE_W | Requested rate in MHz (0 selects the default) |
| rate_q | output | RATE_W | Active, limited rate in MHz |
| cpu_ce | output | 1 | One-system-cycle processor clock enable |

## Verification
A wrong accumulator value shows up as a pulse count that is off by one in the very next `SYS_MHZ`-cycle window. A stuck or leaking update state shows up at the first pulse after a write, as a `rate_q` value that is not the last limited request, or as a `rate_q` that changes with `cpu_ce` low in the cycle before. A wrong limit or default shows on `rate_q` one pulse after the write. The bench therefore checks `rate_q` at the cycle the change is due and counts pulses over a full window after each change.

// File: rtl/cerate_pkg.sv
package cerate_pkg;

    // Update-path states: nothing pending, or a limited request waiting for a pulse
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } upd_state_t;

    // Fixed default rate selected by power-on reset and by a zero request
    localparam int DEF_MHZ = 4;

endpackage

// File: rtl/cerate_clamp.sv
module cerate_clamp #(
    parameter int RATE_W  = 8,
    parameter int MAX_MHZ = 50,
    parameter int DEF_MHZ = 4
) (
    input  logic [RATE_W-1:0] req,
    output logic [RATE_W-1:0] lim
);
    localparam logic [RATE_W-1:0] MAX_V = RATE_W'(MAX_MHZ);
    localparam logic [RATE_W-1:0] DEF_V = RATE_W'(DEF_MHZ);

    always_comb begin
        if (req == '0) begin
            lim = DEF_V;
        end else if (req > MAX_V) begin
            lim = MAX_V;
        end else begin
            lim = req;
        end
    end
endmodule

// File: rtl/cerate_upd_fsm.sv
module cerate_upd_fsm
    import cerate_pkg::*;
#(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              wr_en,
    input  logic [RATE_W-1:0] wr_lim,
    input  logic              ce_now,
    output logic [RATE_W-1:0] rate_q,
    output upd_state_t        state_q
);
    localparam logic [RATE_W-1:0] DEF_V = RATE_W'(DEF_MHZ);

    upd_state_t        state_d;
    logic [RATE_W-1:0] pend_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_en && !ce_now) begin
                    state_d = ST_WAIT;   // post
                end
            end
            ST_WAIT: begin
                if (ce_now) begin
                    state_d = ST_IDLE;   // commit
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (por_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data registers: pending request and active rate
    always_ff @(posedge clk) begin
        if (por_rst) begin
            pend_q <= DEF_V;
            rate_q <= DEF_V;
        end else begin
            if (wr_en) begin
                pend_q <= wr_lim;
            end
            if (ce_now) begin
                if (wr_en) begin
                    rate_q <= wr_lim;
                end else if (state_q == ST_WAIT) begin
                    rate_q <= pend_q;
                end
            end
        end
    end
endmodule

// File: rtl/cerate_accum.sv
module cerate_accum #(
    parameter int SYS_MHZ = 100,
    parameter int RATE_W  = 8,
    parameter int SUM_W   = 9
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              brk_rst,
    input  logic [RATE_W-1:0] rate,
    output logic [SUM_W-1:0]  acc_q,
    output logic              ce_q
);
    localparam logic [SUM_W-1:0] SYS_V = SUM_W'(SYS_MHZ);

    logic [SUM_W-1:0] sum;
    logic             hit;

    always_comb begin
        sum = acc_q + SUM_W'(rate);
        hit = (sum >= SYS_V);
    end

    always_ff @(posedge clk) begin
        if (por_rst || brk_rst) begin
            acc_q <= '0;
            ce_q  <= 1'b0;
        end else if (hit) begin
            acc_q <= sum - SYS_V;
            ce_q  <= 1'b1;
        end else begin
            acc_q <= sum;
            ce_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/cerate_ctrl.sv
module cerate_ctrl
    import cerate_pkg::*;
#(
    parameter int SYS_MHZ = 100,
    parameter int MAX_MHZ = 50,
    parameter int RATE_W  = 8
) (
    input  logic              clk,
    input  logic              por_rst,
    input  logic              brk_rst,
    input  logic              wr_en,
    input  logic [RATE_W-1:0] wr_rate,
    output logic [RATE_W-1:0] rate_q,
    output logic              cpu_ce
);
    localparam int ACC_W = $clog2(2 * SYS_MHZ);
    localparam int SUM_W = ((ACC_W > RATE_W) ? ACC_W : RATE_W) + 1;

    // Elaboration-time parameter checks
    if (MAX_MHZ > SYS_MHZ) begin : g_bad_max
        $error("MAX_MHZ must not exceed SYS_MHZ");
    end
    if (DEF_MHZ > MAX_MHZ) begin : g_bad_def
        $error("default rate must not exceed MAX_MHZ");
    end
    if (MAX_MHZ >= (1 << RATE_W)) begin : g_bad_width
        $error("RATE_W too narrow for MAX_MHZ");
    end

    logic [RATE_W-1:0] wr_lim;
    logic [SUM_W-1:0]  acc_q;
    upd_state_t        upd_state;

    cerate_clamp #(
        .RATE_W (RATE_W),
        .MAX_MHZ(MAX_MHZ),
        .DEF_MHZ(DEF_MHZ)
    ) u_clamp (
        .req(wr_rate),
        .lim(wr_lim)
    );

    cerate_upd_fsm #(
        .RATE_W(RATE_W)
    ) u_upd (
        .clk    (clk),
        .por_rst(por_rst),
        .wr_en  (wr_en),
        .wr_lim (wr_lim),
        .ce_now (cpu_ce),
        .rate_q (rate_q),
        .state_q(upd_state)
    );

    cerate_accum #(
        .SYS_MHZ(SYS_MHZ),
        .RATE_W (RATE_W),
        .SUM_W  (SUM_W)
    ) u_acc (
        .clk    (clk),
        .por_rst(por_rst),
        .brk_rst(brk_rst),
        .rate   (rate_q),
        .acc_q  (acc_q),
        .ce_q   (cpu_ce)
    );
endmodule

// File: rtl/cerate_ctrl_chk.sv
module cerate_ctrl_chk #(
    parameter int SYS_MHZ = 100,
    parameter int MAX_MHZ = 50,
    parameter int RATE_W  = 8,
    parameter int SUM_W   = 9
) (
    input logic              clk,
    input logic              por_rst,
    input logic              brk_rst,
    input logic [RATE_W-1:0] rate_q,
    input logic              cpu_ce,
    input logic [SUM_W-1:0]  acc_q
);
    // R1
    por_default_chk: assert property (@(posedge clk)
        por_rst |=> (int'(rate_q) == 4 && !cpu_ce));

    // R10
    acc_below_sys_chk: assert property (@(posedge clk) disable iff (por_rst)
        int'(acc_q) < SYS_MHZ);

    // R3
    rate_range_chk: assert property (@(posedge clk) disable iff (por_rst)
        (rate_q != '0) && (int'(rate_q) <= MAX_MHZ));

    // R6
    rate_step_chk: assert property (@(posedge clk) disable iff (por_rst)
        (rate_q != $past(rate_q)) |-> $past(cpu_ce));

    // R8
    brk_quiet_chk: assert property (@(posedge clk) disable iff (por_rst)
        brk_rst |=> !cpu_ce);

    // R9
    full_rate_chk: assert property (@(posedge clk) disable iff (por_rst)
        (int'(rate_q) == SYS_MHZ && !brk_rst) |=> cpu_ce);
endmodule

bind cerate_ctrl cerate_ctrl_chk #(
    .SYS_MHZ(SYS_MHZ),
    .MAX_MHZ(MAX_MHZ),
    .RATE_W (RATE_W),
    .SUM_W  (SUM_W)
) u_chk (
    .clk    (clk),
    .por_rst(por_rst),
    .brk_rst(brk_rst),
    .rate_q (rate_q),
    .cpu_ce (cpu_ce),
    .acc_q  (acc_q)
);

// File: tb/cerate_ctrl_test.sv
module cerate_ctrl_test;
    localparam int SYS = 100;
    localparam int MAX = 50;
    localparam int RW  = 8;

    logic          clk = 1'b0;
    logic          por_rst = 1'b1;
    logic          brk_rst = 1'b0;
    logic          wr_en = 1'b0;
    logic [RW-1:0] wr_rate = '0;
    logic [RW-1:0] rate_q;
    logic          cpu_ce;

    logic          f_wr_en = 1'b0;
    logic [RW-1:0] f_wr_rate = '0;
    logic [RW-1:0] f_rate_q;
    logic          f_cpu_ce;

    int total = 0;
    int bad   = 0;

    always #4ns clk = ~clk;

    cerate_ctrl #(.SYS_MHZ(SYS), .MAX_MHZ(MAX), .RATE_W(RW)) uut (
        .clk(clk), .por_rst(por_rst), .brk_rst(brk_rst),
        .wr_en(wr_en), .wr_rate(wr_rate), .rate_q(rate_q), .cpu_ce(cpu_ce)
    );

    // Second instance whose maximum equals its system rate
    cerate_ctrl #(.SYS_MHZ(8), .MAX_MHZ(8), .RATE_W(RW)) uut_full (
        .clk(clk), .por_rst(por_rst), .brk_rst(brk_rst),
        .wr_en(f_wr_en), .wr_rate(f_wr_rate), .rate_q(f_rate_q), .cpu_ce(f_cpu_ce)
    );

    localparam int VEC_N = 8;
    localparam int VEC_REQ [VEC_N] = '{0, 3, 4, 1, 50, 51, 255, 17};
    localparam int VEC_EXP [VEC_N] = '{4, 3, 4, 1, 50, 50, 50, 17};

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Wait until a pulse has been seen; return one negedge after it
    task automatic wait_pulse(input logic seen_first);
        logic seen = seen_first;
        int   guard = 0;
        while (!seen && guard < SYS + 5) begin
            seen = cpu_ce;
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic set_rate(input int v, input int exp, input string tag);
        logic seen;
        @(negedge clk);
        wr_rate = RW'(v);
        wr_en   = 1'b1;
        seen    = cpu_ce;
        @(negedge clk);
        wr_en = 1'b0;
        wait_pulse(seen);
        chk(tag, int'(rate_q), exp);
    endtask

    task automatic count_window(input int exp, input string tag);
        int n = 0;
        repeat (SYS) begin
            @(negedge clk);
            n += int'(cpu_ce);
        end
        chk(tag, n, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rate in reset", int'(rate_q), 4);
        chk("R1 ce in reset", int'(cpu_ce), 0);
        por_rst = 1'b0;
        @(negedge clk);
        chk("R1 ce after reset", int'(cpu_ce), 0);
        count_window(4, "R5 default window");

        // Table walk: R2 zero, R3 above max, R4 in range, R5 pulse counts
        for (int i = 0; i < VEC_N; i++) begin
            set_rate(VEC_REQ[i], VEC_EXP[i], "R2/R3/R4 limited rate");
            count_window(VEC_EXP[i], "R5 window count");
        end

        // R6 and R7: several writes before the next pulse
        set_rate(1, 1, "R4 rate one");
        wait_pulse(1'b0);
        @(negedge clk);
        wr_rate = 8'd9;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_rate = 8'd23;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R6 rate held before pulse", int'(rate_q), 1);
        wait_pulse(1'b0);
        chk("R7 last write wins", int'(rate_q), 23);
        count_window(23, "R5 after replace");

        // R8: soft break keeps rate and silences the enable
        set_rate(17, 17, "R4 rate seventeen");
        @(negedge clk);
        brk_rst = 1'b1;
        repeat (6) begin
            @(negedge clk);
            chk("R8 ce low in break", int'(cpu_ce), 0);
        end
        brk_rst = 1'b0;
        chk("R8 rate kept", int'(rate_q), 17);
        count_window(17, "R8 resume count");

        // R1: power-on reset restores the default
        por_rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 por restores default", int'(rate_q), 4);
        chk("R1 full instance default", int'(f_rate_q), 4);
        por_rst = 1'b0;

        // R9: maximum equal to the system rate gives a steady enable
        @(negedge clk);
        f_wr_rate = 8'd8;
        f_wr_en   = 1'b1;
        @(negedge clk);
        f_wr_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 full rate set", int'(f_rate_q), 8);
        repeat (20) begin
            @(negedge clk);
            chk("R9 ce every cycle", int'(f_cpu_ce), 1);
        end
        f_wr_rate = 8'd200;
        f_wr_en   = 1'b1;
        @(negedge clk);
        f_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 full clamp", int'(f_rate_q), 8);
        chk("R9 ce still high", int'(f_cpu_ce), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule